// File: doc/BRIEF.md
# Byte-stream program bootstrap loader

This block fills program memory from a byte stream on an external port. After a start trigger with a mode that selects a byte-stream source, it accepts bytes over a valid/ready handshake. It packs every three bytes into one 24-bit word, with the low byte arriving first.

The first word gives how many program words follow. The second word gives the load address. Each later word is written to program memory, one address above the previous one. Once the last program word has been written, the loader raises a one-clock jump request that carries the load address. It then returns to idle.

The loader sits between a port receiver and the program memory write port. The processor core takes the jump request as the point at which it starts running the loaded program.

Top module: `stream_boot_loader`

## Requirements
- R1: While reset is active, and after it is released, `byte_ready_o`, `mem_we_o` and `jump_o` are all 0.
- R2: A start pulse is ignored when the low three bits of `mode_i` are zero (mode values 0 and 8), and `byte_ready_o` stays 0. A start pulse with any other mode value raises `byte_ready_o` in the next cycle.
- R3: A byte is taken only in a cycle where both `byte_valid_i` and `byte_ready_o` are 1. Each group of three bytes forms a word, and the first byte of the group is bits 7:0, the second is bits 15:8 and the third is bits 23:16.
- R4: The first word is the count N and the second word is the load address A. After them, exactly N program words are written, and word k goes to address A+k.
- R5: Write addresses wrap from 0xFFFFFF to 0x000000.
- R6: `jump_o` is a pulse one clock long. While it is high, `jump_addr_o` equals A. It is high in the same cycle as the write strobe of the last program word.
- R7: When N is zero, no write takes place. `jump_o` is high in the cycle that follows the clock edge on which the last address byte is taken.
- R8: After the jump, `byte_ready_o` is 0 until the next accepted start, and bytes offered in that time cause neither writes nor jumps.
- R9: `mem_we_o` is high for exactly one cycle per program word. It rises only after a clock edge on which a byte was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start trigger, sampled only while idle |
| mode_i | input | 4 | Load source mode; 0 and 8 do not start a load |
| byte_valid_i | input | 1 | Incoming byte is valid |
| byte_data_i | input | 8 | Incoming byte |
| byte_ready_o | output | 1 | Loader can take a byte |
| mem_we_o | output | 1 | Program memory write strobe |
| mem_addr_o | output | 24 | Program memory write address |
| mem_wdata_o | output | 24 | Program memory write data |
| jump_o | output | 1 | One-cycle request to jump to the loaded program |
| jump_addr_o | output | 24 | Jump target, valid while jump_o is high |

## Verification
The assertions place no limits on `byte_valid_i`, `byte_data_i` or on when `start_i` is asserted. They do assume that a reset is the only way a load can be cut short, because the address-step and jump-target checks keep their history from the first write of a load until its jump. Every bench scenario lets each load run until its jump before the next scenario starts.

The stimulus inserts random gaps between bytes. It also offers bytes while the loader is idle and pulses start with the modes that are not allowed. These exercise the handshake and the ignore rules without breaking that assumption.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEN  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_JUMP = 3'd4
  } sbl_state_e;

  // A mode selects a byte-stream source unless its low bits are all zero.
  function automatic logic mode_loads(input logic [3:0] mode);
    return (mode[2:0] != 3'd0);
  endfunction

endpackage

// File: rtl/sbl_reset_sync.sv
module sbl_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sbl_word_assembler.sv
module sbl_word_assembler #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     take_i,
  input  logic [BYTE_W-1:0]        byte_i,
  output logic [BYTE_W*NBYTES-1:0] word_o,
  output logic                     word_stb_o
);
  localparam int WORD_W = BYTE_W * NBYTES;
  localparam int IDX_W  = (NBYTES > 2) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)            idx_d = '0;
    else if (take_i)      idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // Lower lanes are held in registers; the top lane comes straight from the input.
  for (genvar g = 0; g < NBYTES - 1; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              lane_en;
    assign lane_en = take_i && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= byte_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
  end

  assign word_o[WORD_W-1 -: BYTE_W] = byte_i;
  assign word_stb_o = take_i && (idx_q == LAST_IDX) && !clr_i;
endmodule

// File: rtl/sbl_sequencer.sv
module sbl_sequencer
  import sbl_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_stb_i,
  output logic              ready_o,
  output logic              clr_o,
  output logic              we_o,
  output logic [WORD_W-1:0] waddr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              jump_o,
  output logic [WORD_W-1:0] jump_addr_o
);
  sbl_state_e        state_q, state_d;
  logic [WORD_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic [WORD_W-1:0] wptr_q, wptr_d;
  logic              we_q, we_d;
  logic [WORD_W-1:0] waddr_q, wdata_q;
  logic              mode_ok;

  assign mode_ok = (mode_i[MODE_W-2:0] != '0);

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    base_d  = base_q;
    wptr_d  = wptr_q;
    we_d    = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i && mode_ok) state_d = ST_LEN;
      ST_LEN: if (word_stb_i) begin
        left_d  = word_i;
        state_d = ST_ADDR;
      end
      ST_ADDR: if (word_stb_i) begin
        base_d  = word_i;
        wptr_d  = word_i;
        state_d = (left_q == '0) ? ST_JUMP : ST_DATA;
      end
      ST_DATA: if (word_stb_i) begin
        we_d    = 1'b1;
        wptr_d  = wptr_q + 1'b1;
        left_d  = left_q - 1'b1;
        if (left_q == WORD_W'(1)) state_d = ST_JUMP;
      end
      ST_JUMP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      base_q  <= '0;
      wptr_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      base_q  <= base_d;
      wptr_q  <= wptr_d;
      we_q    <= we_d;
    end
  end

  // Write port registers load only on a write (explicit clock enable).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (we_d) begin
      waddr_q <= wptr_q;
      wdata_q <= word_i;
    end
  end

  assign ready_o     = (state_q == ST_LEN) || (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign clr_o       = (state_q == ST_IDLE);
  assign jump_o      = (state_q == ST_JUMP);
  assign jump_addr_o = base_q;
  assign we_o        = we_q;
  assign waddr_o     = waddr_q;
  assign wdata_o     = wdata_q;
endmodule

// File: rtl/stream_boot_loader.sv
module stream_boot_loader #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  parameter int MODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [MODE_W-1:0]        mode_i,
  input  logic                     byte_valid_i,
  input  logic [BYTE_W-1:0]        byte_data_i,
  output logic                     byte_ready_o,
  output logic                     mem_we_o,
  output logic [BYTE_W*NBYTES-1:0] mem_addr_o,
  output logic [BYTE_W*NBYTES-1:0] mem_wdata_o,
  output logic                     jump_o,
  output logic [BYTE_W*NBYTES-1:0] jump_addr_o
);
  localparam int WORD_W = BYTE_W * NBYTES;

  logic              rst_core_n;
  logic              take;
  logic              clr;
  logic              ready;
  logic [WORD_W-1:0] word;
  logic              word_stb;

  sbl_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign take = byte_valid_i && ready;

  sbl_word_assembler #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_asm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr_i      (clr),
    .take_i     (take),
    .byte_i     (byte_data_i),
    .word_o     (word),
    .word_stb_o (word_stb)
  );

  sbl_sequencer #(.WORD_W(WORD_W), .MODE_W(MODE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .word_i      (word),
    .word_stb_i  (word_stb),
    .ready_o     (ready),
    .clr_o       (clr),
    .we_o        (mem_we_o),
    .waddr_o     (mem_addr_o),
    .wdata_o     (mem_wdata_o),
    .jump_o      (jump_o),
    .jump_addr_o (jump_addr_o)
  );

  assign byte_ready_o = ready;
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  parameter int MODE_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start_i,
  input logic [MODE_W-1:0]        mode_i,
  input logic                     byte_valid_i,
  input logic                     byte_ready_o,
  input logic                     mem_we_o,
  input logic [BYTE_W*NBYTES-1:0] mem_addr_o,
  input logic                     jump_o,
  input logic [BYTE_W*NBYTES-1:0] jump_addr_o
);
  localparam int WORD_W = BYTE_W * NBYTES;

  logic              seen_q;
  logic [WORD_W-1:0] prev_q;
  logic [WORD_W-1:0] first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      prev_q  <= '0;
      first_q <= '0;
    end else if (jump_o) begin
      seen_q  <= 1'b0;
    end else if (mem_we_o) begin
      seen_q  <= 1'b1;
      prev_q  <= mem_addr_o;
      if (!seen_q) first_q <= mem_addr_o;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !mem_we_o && !jump_o && !byte_ready_o);

  assert_bad_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_ready_o && start_i && mode_i[MODE_W-2:0] == '0) |=> !byte_ready_o);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && seen_q) |-> (mem_addr_o == prev_q + 1'b1));

  assert_jump_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |=> !jump_o);

  assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_o && seen_q) |-> (jump_addr_o == first_q));

  assert_idle_after_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |=> !byte_ready_o);

  assert_we_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);

  assert_we_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> $past(byte_valid_i && byte_ready_o));
endmodule

bind stream_boot_loader sbl_checker #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .MODE_W(MODE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .jump_o       (jump_o),
  .jump_addr_o  (jump_addr_o)
);

// File: tb/sim_stream_boot_loader.sv
module sim_stream_boot_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = 4'd0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = 8'd0;
  logic        byte_ready_o;
  logic        mem_we_o;
  logic [23:0] mem_addr_o;
  logic [23:0] mem_wdata_o;
  logic        jump_o;
  logic [23:0] jump_addr_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int          nwr;
  int          njump;
  int          jump_cyc;
  int          last_wr_cyc;
  int          acc_cyc;
  logic [23:0] jump_seen;
  logic [23:0] wr_addr [64];
  logic [23:0] wr_data [64];
  logic [23:0] wbuf [64];

  always #4 clk = ~clk;

  stream_boot_loader u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .byte_ready_o(byte_ready_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .jump_o(jump_o), .jump_addr_o(jump_addr_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_we_o) begin
      if (nwr < 64) begin
        wr_addr[nwr] = mem_addr_o;
        wr_data[nwr] = mem_wdata_o;
      end
      nwr = nwr + 1;
      last_wr_cyc = cyc;
    end
    if (jump_o) begin
      njump = njump + 1;
      jump_seen = jump_addr_o;
      jump_cyc = cyc;
    end
  end

  function automatic logic [7:0] byte_of(input logic [23:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  function automatic logic [23:0] exp_addr(input logic [23:0] base, input int k);
    return base + 24'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    nwr = 0; njump = 0; jump_cyc = -1; last_wr_cyc = -1; jump_seen = '0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    int gap;
    gap = $urandom_range(0, 2);
    for (int i = 0; i < gap; i++) begin
      byte_valid_i = 1'b0;
      byte_data_i  = 8'($urandom);
      @(negedge clk);
    end
    byte_valid_i = 1'b1;
    byte_data_i  = b;
    while (!byte_ready_o) @(negedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    byte_valid_i = 1'b0;
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int k = 0; k < 3; k++) send_byte(byte_of(w, k));
  endtask

  task automatic do_start(input logic [3:0] m);
    mode_i  = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mode_i  = 4'($urandom);
  endtask

  task automatic run_load(input int n, input logic [23:0] base, input string rq);
    clear_mon();
    for (int k = 0; k < n; k++) wbuf[k] = 24'($urandom);
    do_start(4'(1 + $urandom_range(0, 6)));
    chk(byte_ready_o == 1'b1, "R2", "ready after valid start", 32'(byte_ready_o), 32'd1);
    send_word(24'(n));
    send_word(base);
    for (int k = 0; k < n; k++) send_word(wbuf[k]);
    repeat (3) @(negedge clk);
    chk(nwr == n, "R4", "write count", 32'(nwr), 32'(n));
    for (int k = 0; k < n && k < nwr; k++) begin
      chk(wr_addr[k] == exp_addr(base, k), rq, "write address", 32'(wr_addr[k]), 32'(exp_addr(base, k)));
      chk(wr_data[k] == wbuf[k], "R3", "write data byte order", 32'(wr_data[k]), 32'(wbuf[k]));
    end
    chk(njump == 1, "R6", "jump pulse count", 32'(njump), 32'd1);
    chk(jump_seen == base, "R6", "jump target", 32'(jump_seen), 32'(base));
    chk(jump_cyc == acc_cyc, n == 0 ? "R7" : "R6", "jump cycle", 32'(jump_cyc), 32'(acc_cyc));
    if (n > 0) chk(last_wr_cyc == jump_cyc, "R6", "last write with jump", 32'(last_wr_cyc), 32'(jump_cyc));
    chk(byte_ready_o == 1'b0, "R8", "idle after jump", 32'(byte_ready_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_mon();
    repeat (3) @(negedge clk);
    chk(!byte_ready_o && !mem_we_o && !jump_o, "R1", "outputs in reset",
        {29'd0, byte_ready_o, mem_we_o, jump_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!byte_ready_o && !mem_we_o && !jump_o, "R1", "outputs after reset",
        {29'd0, byte_ready_o, mem_we_o, jump_o}, 32'd0);

    // R3/R8: bytes offered while idle are not taken
    byte_valid_i = 1'b1;
    for (int i = 0; i < 6; i++) begin
      byte_data_i = 8'($urandom);
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
    chk(nwr == 0 && njump == 0 && !byte_ready_o, "R8", "idle ignores bytes",
        32'(nwr + njump), 32'd0);

    // R2: modes 0 and 8 do not start a load
    do_start(4'd0);
    repeat (2) @(negedge clk);
    chk(byte_ready_o == 1'b0, "R2", "mode 0 ignored", 32'(byte_ready_o), 32'd0);
    do_start(4'd8);
    repeat (2) @(negedge clk);
    chk(byte_ready_o == 1'b0, "R2", "mode 8 ignored", 32'(byte_ready_o), 32'd0);

    // Directed corners
    run_load(0, 24'h123456, "R7");
    chk(nwr == 0, "R7", "no writes for zero count", 32'(nwr), 32'd0);
    run_load(1, 24'h000100, "R4");
    run_load(4, 24'hFFFFFE, "R5");
    chk(wr_addr[2] == 24'h000000, "R5", "address wraps", 32'(wr_addr[2]), 32'd0);

    // R9: strobe count equals word count under random gaps
    run_load(5, 24'h00ABCD, "R9");

    // Random loads
    for (int t = 0; t < 12; t++) begin
      run_load($urandom_range(1, 20), 24'($urandom), "R4");
    end

    // R8: bytes after a jump are ignored
    clear_mon();
    byte_valid_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      byte_data_i = 8'($urandom);
      @(negedge clk);
    end
    byte_valid_i = 1'b0;
    chk(nwr == 0 && njump == 0 && !byte_ready_o, "R8", "post-jump bytes ignored",
        32'(nwr + njump), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule